// File: doc/BRIEF.md
# Vector Masked Merge Unit

This block carries out the vector merge and vector move operations for one vector register. A one-cycle `start` pulse hands it a 32-bit instruction word, a 64-bit scalar, the active vector length, the element width and the mask stride. It decodes the word and checks that it is legal. It then walks the element slots of the destination one per clock.

Each body element comes either from the second vector source or from the first operand. The first operand is a vector element, the truncated scalar or the sign-extended 5-bit immediate. The choice depends on the instruction's mask-enable bit and on a bit of register v0. Element slots at or past the active length are cleared. The finished register is written back in a single write, in the same cycle as a one-cycle `done` pulse.

The register file sits outside the block. The unit drives two read addresses and receives the data combinationally. It sees v0 on a dedicated mask input and owns a single whole-register write port. Register grouping is not modelled: every operand is exactly one register of `VLEN` bits.

Top module: `vmerge_unit`

## Requirements
- R1: The word is accepted only when bits [6:0] are 1010111, bits [31:26] are 010111 and bits [14:12] are 000 (vector-vector), 100 (vector-scalar) or 011 (vector-immediate). Bit 25 is the mask enable `vm`, bits [24:20] the second source, bits [19:15] the first source or immediate, and bits [11:7] the destination. Any other word is illegal.
- R2: With vm=0, a body element i takes the second-source element when its mask bit is 0, and the first operand when the mask bit is 1.
- R3: With vm=1, every body element takes the first operand. The word is illegal unless bits [24:20] are zero.
- R4: A word with vm=0 and destination field 0 is illegal.
- R5: `sew` values 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Element i occupies bits [i*SEW +: SEW], and the number of slots is VLEN/SEW.
- R6: In the vector-scalar form the scalar is truncated to the element width. In the vector-immediate form bits [19:15] are sign-extended to the element width.
- R7: The mask bit of element i is v0 bit i*mlen. A position of VLEN or more reads as 0.
- R8: When vl is nonzero, every slot with index at or above vl is written as zero. A vl larger than the slot count leaves no tail.
- R9: For a legal word with vl nonzero, `done` is high for exactly one cycle, VLEN/SEW+1 cycles after the start edge. A single write of the destination register accompanies it.
- R10: For an illegal word, `done` and `illegal` rise together one cycle after start, and no register is written.
- R11: With vl equal to 0 and a legal word, `done` rises one cycle after start with `illegal` low, and the destination keeps its contents.
- R12: A `start` pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 32 | Instruction word |
| scalar | input | 64 | Scalar operand for the vector-scalar form |
| vl | input | VL_W | Active vector length |
| sew | input | 2 | Element width code (0..3 = 8..64 bits) |
| mlen | input | MLEN_W | Stride between mask bits in v0 |
| rs1Addr | output | 5 | Read address of the first vector source |
| rs1Data | input | VLEN | Contents of the first vector source |
| rs2Addr | output | 5 | Read address of the second vector source |
| rs2Data | input | VLEN | Contents of the second vector source |
| maskData | input | VLEN | Contents of v0 |
| wrEn | output | 1 | Destination write strobe |
| wrAddr | output | 5 | Destination register number |
| wrData | output | VLEN | Full destination register value |
| done | output | 1 | Operation finished (one cycle) |
| illegal | output | 1 | Instruction rejected, qualified by done |

## Verification
All three operand forms are swept across every element width, both mask-enable values and every vl from 0 to one past the slot count, each time with fresh pseudo-random register contents. Mixed mask patterns show whether the source is chosen per element rather than per register. Alternating the mask stride between 1 and the element width shows whether the mask position is computed correctly. A stride large enough to run past v0 checks that such positions read as 0. Sweeping vl through and beyond the slot count separates body, tail and the untouched vl=0 case. Single words with each illegal field combination, and a start issued mid-run, check the rejection and the ignore paths.

// File: rtl/vmerge_pkg.sv
package vmerge_pkg;

  localparam int ELEN = 64;

  localparam logic [6:0] OPC_VEC   = 7'b1010111;
  localparam logic [5:0] FN6_MERGE = 6'b010111;
  localparam logic [2:0] FN3_VV    = 3'b000;
  localparam logic [2:0] FN3_VX    = 3'b100;
  localparam logic [2:0] FN3_VI    = 3'b011;

  typedef enum logic [1:0] {
    FORM_VV = 2'd0,
    FORM_VX = 2'd1,
    FORM_VI = 2'd2
  } opForm_e;

  typedef struct packed {
    logic    legal;
    opForm_e form;
    logic    vm;
    logic [4:0] vd;
    logic [4:0] src1;
    logic [4:0] src2;
  } decoded_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic commit;
  } dpCtl_t;

endpackage

// File: rtl/vmerge_decode.sv
module vmerge_decode
  import vmerge_pkg::*;
(
  input  logic [31:0] instr,
  output decoded_t    dec
);

  logic [2:0] fn3;
  logic       fmtOk;
  logic       maskRuleOk;

  assign fn3 = instr[14:12];

  always_comb begin
    dec.form = FORM_VV;
    fmtOk    = 1'b1;
    unique case (fn3)
      FN3_VV:  dec.form = FORM_VV;
      FN3_VX:  dec.form = FORM_VX;
      FN3_VI:  dec.form = FORM_VI;
      default: fmtOk = 1'b0;
    endcase
  end

  assign dec.vm   = instr[25];
  assign dec.src2 = instr[24:20];
  assign dec.src1 = instr[19:15];
  assign dec.vd   = instr[11:7];

  // unmasked move needs a zero second-source field; masked form may not target v0
  assign maskRuleOk = dec.vm ? (dec.src2 == 5'd0) : (dec.vd != 5'd0);

  assign dec.legal = (instr[6:0] == OPC_VEC) && (instr[31:26] == FN6_MERGE)
                     && fmtOk && maskRuleOk;

endmodule

// File: rtl/vmerge_ctrl.sv
module vmerge_ctrl
  import vmerge_pkg::*;
#(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            decLegal,
  input  logic [VL_W-1:0] vl,
  input  logic            lastElem,
  output dpCtl_t          ctl,
  output logic            done,
  output logic            illegal
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } state_e;

  state_e stateQ;
  logic   illegalQ;
  logic   skipQ;
  logic   noWork;

  assign noWork = !decLegal || (vl == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      illegalQ <= 1'b0;
      skipQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            illegalQ <= !decLegal;
            skipQ    <= noWork;
            stateQ   <= noWork ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (lastElem) stateQ <= ST_FIN;
        end
        ST_FIN: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (stateQ == ST_IDLE) && start;
    ctl.step   = (stateQ == ST_RUN);
    ctl.commit = (stateQ == ST_FIN) && !skipQ;
  end

  assign done    = (stateQ == ST_FIN);
  assign illegal = (stateQ == ST_FIN) && illegalQ;

endmodule

// File: rtl/vmerge_datapath.sv
module vmerge_datapath
  import vmerge_pkg::*;
#(
  parameter int VLEN   = 64,
  parameter int VL_W   = 8,
  parameter int MLEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  opForm_e           form,
  input  logic              vm,
  input  logic [4:0]        vd,
  input  logic [4:0]        src1,
  input  logic [4:0]        src2,
  input  logic [1:0]        sew,
  input  logic [VL_W-1:0]   vl,
  input  logic [MLEN_W-1:0] mlen,
  input  logic [ELEN-1:0]   scalar,
  input  logic [VLEN-1:0]   rs1Data,
  input  logic [VLEN-1:0]   rs2Data,
  input  logic [VLEN-1:0]   maskData,
  output logic [4:0]        rs1Addr,
  output logic [4:0]        rs2Addr,
  output logic              lastElem,
  output logic              wrEn,
  output logic [4:0]        wrAddr,
  output logic [VLEN-1:0]   wrData
);

  localparam int NB    = VLEN / 8;
  localparam int IDX_W = $clog2(NB);
  localparam int SH_W  = IDX_W + 3;
  localparam int PW    = IDX_W + MLEN_W;

  opForm_e           formQ;
  logic              vmQ;
  logic [4:0]        vdQ, s1Q, s2Q;
  logic [1:0]        sewQ;
  logic [VL_W-1:0]   vlQ;
  logic [MLEN_W-1:0] mlenQ;
  logic [ELEN-1:0]   scalarQ;
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      formQ   <= FORM_VV;
      vmQ     <= 1'b0;
      vdQ     <= '0;
      s1Q     <= '0;
      s2Q     <= '0;
      sewQ    <= '0;
      vlQ     <= '0;
      mlenQ   <= '0;
      scalarQ <= '0;
      idxQ    <= '0;
    end else if (ctl.load) begin
      formQ   <= form;
      vmQ     <= vm;
      vdQ     <= vd;
      s1Q     <= src1;
      s2Q     <= src2;
      sewQ    <= sew;
      vlQ     <= vl;
      mlenQ   <= mlen;
      scalarQ <= scalar;
      idxQ    <= '0;
    end else if (ctl.step) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  // slot count of the register at the latched element width
  logic [IDX_W:0] vlmax, vlmaxM1;
  assign vlmax    = (IDX_W+1)'(NB) >> sewQ;
  assign vlmaxM1  = vlmax - 1'b1;
  assign lastElem = ({1'b0, idxQ} == vlmaxM1);

  logic isTail;
  assign isTail = ({{(VL_W-IDX_W){1'b0}}, idxQ} >= vlQ);

  // mask bit position i*mlen
  logic [PW-1:0] mPos;
  logic          maskBit;
  assign mPos    = {{MLEN_W{1'b0}}, idxQ} * {{IDX_W{1'b0}}, mlenQ};
  assign maskBit = (mPos < PW'(VLEN)) ? maskData[mPos[SH_W-1:0]] : 1'b0;

  // element extraction
  logic [SH_W-1:0] shAmt;
  logic [VLEN-1:0] src1Sh, src2Sh;
  logic [ELEN-1:0] src1Elem, src2Elem, immExt, firstOp, newVal;

  assign shAmt    = {idxQ, 3'b000} << sewQ;
  assign src1Sh   = rs1Data >> shAmt;
  assign src2Sh   = rs2Data >> shAmt;
  assign src1Elem = src1Sh[ELEN-1:0];
  assign src2Elem = src2Sh[ELEN-1:0];
  assign immExt   = {{(ELEN-5){s1Q[4]}}, s1Q};

  always_comb begin
    unique case (formQ)
      FORM_VX: firstOp = scalarQ;
      FORM_VI: firstOp = immExt;
      default: firstOp = src1Elem;
    endcase
    if (isTail)                newVal = '0;
    else if (!vmQ && !maskBit) newVal = src2Elem;
    else                       newVal = firstOp;
  end

  logic [2:0] laneMask;
  assign laneMask = ~(3'b111 << sewQ);

  // one byte register per byte of the destination
  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [IDX_W-1:0] owner;
    logic [2:0]       lane;
    logic [7:0]       byteQ;

    assign owner = IDX_W'(b) >> sewQ;
    assign lane  = 3'(b) & laneMask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              byteQ <= '0;
      else if (ctl.step && (owner == idxQ))   byteQ <= newVal[{lane, 3'b000} +: 8];
    end

    assign wrData[b*8 +: 8] = byteQ;
  end

  assign rs1Addr = s1Q;
  assign rs2Addr = s2Q;
  assign wrEn    = ctl.commit;
  assign wrAddr  = vdQ;

endmodule

// File: rtl/vmerge_unit.sv
module vmerge_unit
  import vmerge_pkg::*;
#(
  parameter int VLEN   = 64,
  parameter int VL_W   = 8,
  parameter int MLEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [63:0]       scalar,
  input  logic [VL_W-1:0]   vl,
  input  logic [1:0]        sew,
  input  logic [MLEN_W-1:0] mlen,
  output logic [4:0]        rs1Addr,
  input  logic [VLEN-1:0]   rs1Data,
  output logic [4:0]        rs2Addr,
  input  logic [VLEN-1:0]   rs2Data,
  input  logic [VLEN-1:0]   maskData,
  output logic              wrEn,
  output logic [4:0]        wrAddr,
  output logic [VLEN-1:0]   wrData,
  output logic              done,
  output logic              illegal
);

  decoded_t dec;
  dpCtl_t   ctl;
  logic     lastElem;

  vmerge_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  vmerge_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .decLegal (dec.legal),
    .vl       (vl),
    .lastElem (lastElem),
    .ctl      (ctl),
    .done     (done),
    .illegal  (illegal)
  );

  vmerge_datapath #(.VLEN(VLEN), .VL_W(VL_W), .MLEN_W(MLEN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .form     (dec.form),
    .vm       (dec.vm),
    .vd       (dec.vd),
    .src1     (dec.src1),
    .src2     (dec.src2),
    .sew      (sew),
    .vl       (vl),
    .mlen     (mlen),
    .scalar   (scalar),
    .rs1Data  (rs1Data),
    .rs2Data  (rs2Data),
    .maskData (maskData),
    .rs1Addr  (rs1Addr),
    .rs2Addr  (rs2Addr),
    .lastElem (lastElem),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/vmerge_unit_chk.sv
module vmerge_unit_chk #(
  parameter int VLEN = 64,
  parameter int VL_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [VL_W-1:0] vl,
  input logic [1:0]      sew,
  input logic            wrEn,
  input logic            done,
  input logic            illegal
);

  localparam int NB = VLEN / 8;

  logic            runC;
  logic [15:0]     cnt;
  logic [1:0]      sewC;
  logic [VL_W-1:0] vlC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runC <= 1'b0;
      cnt  <= '0;
      sewC <= '0;
      vlC  <= '0;
    end else if (start && !runC) begin
      runC <= 1'b1;
      cnt  <= 16'd1;
      sewC <= sew;
      vlC  <= vl;
    end else if (done) begin
      runC <= 1'b0;
    end else if (runC) begin
      cnt <= cnt + 16'd1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !illegal && vlC != '0) |-> (cnt == 16'(NB >> sewC) + 16'd1));

  // R10
  illegal_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  // R10
  no_write_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (done && !illegal));

  // R11
  zero_vl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && vlC == '0) |-> (cnt == 16'd1 && !wrEn));

  // R12
  done_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runC);

endmodule

bind vmerge_unit vmerge_unit_chk #(.VLEN(VLEN), .VL_W(VL_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .vl      (vl),
  .sew     (sew),
  .wrEn    (wrEn),
  .done    (done),
  .illegal (illegal)
);

// File: tb/sim_vmerge_unit.sv
`timescale 1ns/1ps
module sim_vmerge_unit;

  localparam int VLEN = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] scalar = '0;
  logic [7:0]  vl = '0;
  logic [1:0]  sew = '0;
  logic [7:0]  mlen = '0;
  logic [4:0]  rs1Addr, rs2Addr, wrAddr;
  logic [63:0] rs1Data, rs2Data, maskData, wrData;
  logic        wrEn, done, illegal;

  logic [63:0] rf [32];
  logic        ldEn = 1'b0;
  logic [4:0]  ldAddr = '0;
  logic [63:0] ldData = '0;

  int checks = 0;
  int fails  = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (ldEn)      rf[ldAddr] <= ldData;
    else if (wrEn) rf[wrAddr] <= wrData;
  end

  assign rs1Data  = rf[rs1Addr];
  assign rs2Data  = rf[rs2Addr];
  assign maskData = rf[0];

  vmerge_unit #(.VLEN(VLEN), .VL_W(8), .MLEN_W(8)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .scalar(scalar),
    .vl(vl), .sew(sew), .mlen(mlen), .rs1Addr(rs1Addr), .rs1Data(rs1Data),
    .rs2Addr(rs2Addr), .rs2Data(rs2Data), .maskData(maskData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .done(done), .illegal(illegal)
  );

  function automatic logic [63:0] nextRnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // form: 0 vector, 1 scalar, 2 immediate
  function automatic logic [31:0] mkInstr(int form, logic vmB, logic [4:0] s2,
                                          logic [4:0] s1, logic [4:0] d);
    logic [2:0] f3;
    f3 = (form == 0) ? 3'b000 : (form == 1) ? 3'b100 : 3'b011;
    return {6'b010111, vmB, s2, s1, f3, d, 7'b1010111};
  endfunction

  function automatic logic [63:0] model(logic [63:0] old, logic [63:0] v1,
      logic [63:0] v2, logic [63:0] m, logic [63:0] sc, logic [4:0] imm,
      int sw, int vlen_, int ml, logic vmB, int form);
    logic [63:0] res, msk, v;
    int esz, nel;
    esz = 8 << sw;
    nel = 8 >> sw;
    msk = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
    if (vlen_ == 0) return old;
    res = '0;
    for (int i = 0; i < nel; i++) begin
      if (i < vlen_) begin
        logic mb;
        mb = (i * ml < 64) ? m[i*ml] : 1'b0;
        if (!vmB && !mb)    v = (v2 >> (i*esz)) & msk;
        else if (form == 0) v = (v1 >> (i*esz)) & msk;
        else if (form == 1) v = sc & msk;
        else                v = {{59{imm[4]}}, imm} & msk;
      end else begin
        v = '0;
      end
      res = res | (v << (i*esz));
    end
    return res;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input logic [4:0] a, input logic [63:0] d);
    ldEn = 1'b1; ldAddr = a; ldData = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic fillRegs();
    for (int r = 0; r < 5; r++) loadReg(5'(r), nextRnd());
  endtask

  task automatic runOp(input string tag, input logic [31:0] ins, input logic [63:0] sc,
                       input int sw, input int vlen_, input int ml, input logic expIll);
    logic [63:0] old, exp;
    int form, cyc, expLat;
    logic [4:0] d;
    d    = ins[11:7];
    old  = rf[d];
    form = (ins[14:12] == 3'b000) ? 0 : (ins[14:12] == 3'b100) ? 1 : 2;
    if (expIll) exp = old;
    else exp = model(old, rf[ins[19:15]], rf[ins[24:20]], rf[0], sc, ins[19:15],
                     sw, vlen_, ml, ins[25], form);
    expLat = (expIll || vlen_ == 0) ? 1 : (8 >> sw) + 1;
    instr = ins; scalar = sc; sew = 2'(sw); vl = 8'(vlen_); mlen = 8'(ml);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R9 latency"}, 64'(cyc), 64'(expLat));
    chk({tag, " R10 illegal flag"}, {63'd0, illegal}, {63'd0, expIll});
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {63'd0, done}, 64'd0);
    chk({tag, " result"}, rf[d], exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset done", {63'd0, done}, 64'd0);
    chk("R10 reset illegal", {63'd0, illegal}, 64'd0);
    chk("R9 reset wrEn", {63'd0, wrEn}, 64'd0);

    // sweep of forms, widths, mask enable and vl (R2 R3 R5 R6 R7 R8 R11)
    for (int sw = 0; sw < 4; sw++) begin
      for (int form = 0; form < 3; form++) begin
        for (int vmI = 0; vmI < 2; vmI++) begin
          for (int v = 0; v <= (8 >> sw) + 1; v++) begin
            logic [4:0] s1f;
            int ml;
            fillRegs();
            s1f = (form == 2) ? 5'(nextRnd()) : 5'd1;
            ml  = (v % 2 == 1) ? 1 : (8 << sw);
            runOp(vmI ? "R3 move" : "R2 merge",
                  mkInstr(form, 1'(vmI), vmI ? 5'd0 : 5'd2, s1f, 5'd3),
                  nextRnd(), sw, v, ml, 1'b0);
          end
        end
      end
    end

    // R7 mask position running past v0
    fillRegs();
    runOp("R7 wide stride", mkInstr(0, 1'b0, 5'd2, 5'd1, 5'd3), '0, 0, 8, 40, 1'b0);
    // R6 negative immediate and scalar at 16 bits
    fillRegs();
    runOp("R6 imm", mkInstr(2, 1'b1, 5'd0, 5'b10011, 5'd4), '0, 1, 4, 16, 1'b0);
    runOp("R6 scalar", mkInstr(1, 1'b1, 5'd0, 5'd1, 5'd4), 64'hFFFF_FFFF_FFFF_8001, 1, 3, 16, 1'b0);
    // R8 vl above slot count
    runOp("R8 long vl", mkInstr(0, 1'b1, 5'd0, 5'd1, 5'd3), '0, 2, 200, 32, 1'b0);
    // R11 vl zero on a move targeting v0 (legal, unchanged)
    runOp("R11 zero vl", mkInstr(1, 1'b1, 5'd0, 5'd1, 5'd0), 64'h5, 0, 0, 8, 1'b0);

    // illegal words (R1 R3 R4 R10)
    fillRegs();
    runOp("R1 bad opcode", mkInstr(0, 1'b0, 5'd2, 5'd1, 5'd3) ^ 32'h1, '0, 0, 8, 8, 1'b1);
    runOp("R1 bad funct6", mkInstr(0, 1'b0, 5'd2, 5'd1, 5'd3) ^ 32'h0400_0000, '0, 0, 8, 8, 1'b1);
    runOp("R1 bad funct3", (mkInstr(0, 1'b0, 5'd2, 5'd1, 5'd3) & ~32'h7000) | 32'h1000, '0, 0, 8, 8, 1'b1);
    runOp("R3 move src2 nonzero", mkInstr(0, 1'b1, 5'd2, 5'd1, 5'd3), '0, 0, 8, 8, 1'b1);
    runOp("R4 masked into v0", mkInstr(1, 1'b0, 5'd2, 5'd1, 5'd0), 64'h7, 0, 8, 8, 1'b1);

    // R12 start during run is ignored
    begin
      logic [63:0] expA, old4;
      int cyc;
      fillRegs();
      old4 = rf[4];
      expA = model(rf[3], rf[1], rf[2], rf[0], '0, 5'd1, 0, 8, 8, 1'b0, 0);
      instr = mkInstr(0, 1'b0, 5'd2, 5'd1, 5'd3); sew = 2'd0; vl = 8'd8; mlen = 8'd8;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      @(negedge clk); cyc++;
      @(negedge clk); cyc++;
      instr = mkInstr(2, 1'b1, 5'd0, 5'd7, 5'd4); sew = 2'd3; vl = 8'd1;
      start = 1'b1;
      @(negedge clk); cyc++;
      start = 1'b0;
      while (!done && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      chk("R12 latency unchanged", 64'(cyc), 64'd9);
      @(negedge clk);
      chk("R12 first result", rf[3], expA);
      repeat (12) @(negedge clk);
      chk("R12 second start ignored", rf[4], old4);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule